// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller links a simple request port to a square DRAM array whose row and column addresses share one narrow address bus. Each request arrives with a valid/ready handshake, a read/write flag, a word address and write data. The controller drives the row half of the address under a row strobe and captures the whole selected row into an internal row buffer. It then drives the column half under a column strobe and reads the addressed word from the buffer or merges new data into it. Finally it writes the whole buffer back to the array. The array's reads are destructive, so this writeback is needed after every access, reads included.

A refresh scheduler raises a pending flag once per programmed interval. The controller serves that flag the next time it is idle, ahead of any waiting request. Each refresh activates the next row in ascending order, captures it and writes it back, with no column phase. The four timing parameters set how many clock cycles each phase holds its strobe: row-to-column delay, column latency, writeback hold and precharge.

The state machine has five states. IDLE goes to ACTIVATE on a pending refresh or an accepted request. ACTIVATE goes to COLUMN for requests and straight to WRITEBACK for refresh. COLUMN goes to WRITEBACK, WRITEBACK goes to PRECHARGE, and PRECHARGE returns to IDLE. Each of these transitions happens when that state's cycle count runs out.

Top module: `mux_dram_ctrl`

## Requirements
- R1: During and right after reset the controller is idle. `req_ready` is 1, every strobe is 0 and `rsp_valid` is 0.
- R2: An accepted request drives the row field `req_addr[2*HW-1:HW]` on `mem_addr` with `mem_row_stb` for T_RCD cycles, starting the cycle after acceptance. The column field `req_addr[HW-1:0]` follows under `mem_col_stb` for T_CL cycles, and `mem_addr` holds steady while each strobe is high.
- R3: A read returns the word last written at that address. `rsp_valid` is a single-cycle pulse in the first cycle after the column phase, which is T_RCD+T_CL cycles after the accepting edge.
- R4: A write changes only the addressed word. The other words of the same row keep their values.
- R5: Every access ends with `mem_wb_stb` high for T_RAS cycles, with the row address on `mem_addr` and the buffer on `mem_row_wdata`. The writeback directly follows the column phase.
- R6: `req_ready` is high only while idle. After an acceptance it stays low for at least T_RCD+T_CL+T_RAS+T_RP cycles, and for exactly that many when no refresh intervenes.
- R7: Every RFSH_INT cycles one refresh activates a row and writes it back without a column strobe. Refreshed rows step upward by one and wrap, and stored data survive the sweeps.
- R8: A pending refresh takes priority over a waiting request, so refreshes continue at the programmed rate under a back-to-back request stream.
- R9: At most one of `mem_row_stb`, `mem_col_stb` and `mem_wb_stb` is high in any cycle.
- R10: A write produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HW | Word address: row in the upper half, column in the lower half |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | HW | Shared row/column address bus |
| mem_row_stb | output | 1 | Row strobe: the array presents the addressed row |
| mem_col_stb | output | 1 | Column strobe |
| mem_wb_stb | output | 1 | Writeback strobe: the array stores `mem_row_wdata` in row `mem_addr` |
| mem_row_rdata | input | (1<<HW)*DW | Row read from the array |
| mem_row_wdata | output | (1<<HW)*DW | Row buffer contents written back |

## Verification
The bound checker watches the properties that hold on every cycle:
- the three strobes are mutually exclusive;
- a column phase always comes straight after a row phase;
- writeback follows every column phase;
- ready appears only with all strobes low;
- the shared address is steady under a held strobe;
- the response is a one-cycle pulse.

Only the bench's scenarios can show the rest:
- data integrity through destructive reads and word merges;
- exact latencies;
- the ascending order and rate of refresh;
- refresh keeping its rate under a saturating request stream.

The bench shows these against a behavioural array that erases a row once its row strobe drops.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ACT,
        S_COL,
        S_WB,
        S_PRE
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_RD,
        OP_WR,
        OP_RF
    } op_e;
endpackage

// File: rtl/mux_dly_timer.sv
module mux_dly_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mux_rfsh_sched.sv
module mux_rfsh_sched #(
    parameter int INTERVAL = 60,
    parameter int HW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    output logic          pend,
    output logic [HW-1:0] row
);
    localparam int IW = $clog2(INTERVAL);

    logic [IW-1:0] tick;
    logic          expire;

    assign expire = (tick == IW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
            pend <= 1'b0;
            row  <= '0;
        end else begin
            tick <= expire ? '0 : tick + IW'(1);
            if (expire) begin
                pend <= 1'b1;
            end else if (ack) begin
                pend <= 1'b0;
            end
            if (ack) begin
                row <= row + HW'(1);
            end
        end
    end
endmodule

// File: rtl/mux_row_buffer.sv
module mux_row_buffer #(
    parameter int HW = 3,
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [(1<<HW)*DW-1:0]   row_in,
    input  logic                    merge,
    input  logic [HW-1:0]           col,
    input  logic [DW-1:0]           wdata,
    output logic [(1<<HW)*DW-1:0]   row_q,
    output logic [DW-1:0]           word
);
    localparam int NW = 1 << HW;

    for (genvar g = 0; g < NW; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[g*DW +: DW] <= '0;
            end else if (load) begin
                row_q[g*DW +: DW] <= row_in[g*DW +: DW];
            end else if (merge && (col == HW'(g))) begin
                row_q[g*DW +: DW] <= wdata;
            end
        end
    end

    assign word = row_q[int'(col)*DW +: DW];
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
    import mux_dram_pkg::*;
#(
    parameter int HW       = 3,
    parameter int DW       = 8,
    parameter int T_RP     = 2,
    parameter int T_RCD    = 3,
    parameter int T_CL     = 2,
    parameter int T_RAS    = 3,
    parameter int RFSH_INT = 60
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [2*HW-1:0]         req_addr,
    input  logic [DW-1:0]           req_wdata,
    output logic                    rsp_valid,
    output logic [DW-1:0]           rsp_rdata,
    output logic [HW-1:0]           mem_addr,
    output logic                    mem_row_stb,
    output logic                    mem_col_stb,
    output logic                    mem_wb_stb,
    input  logic [(1<<HW)*DW-1:0]   mem_row_rdata,
    output logic [(1<<HW)*DW-1:0]   mem_row_wdata
);
    localparam int AW   = 2 * HW;
    localparam int ROWW = (1 << HW) * DW;
    localparam int TM1  = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int TM2  = (T_CL > T_RAS) ? T_CL : T_RAS;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int TW   = $clog2(TMAX + 1) + 1;

    ctl_state_e        state_q, nxt;
    op_e               op_q;
    logic [HW-1:0]     row_q, col_q;
    logic [DW-1:0]     wd_q;
    logic              t_start, t_done;
    logic [TW-1:0]     t_len;
    logic              rf_pend, rf_go, acc;
    logic [HW-1:0]     rf_row;
    logic              buf_load, buf_merge, col_fin;
    logic [ROWW-1:0]   buf_row;
    logic [DW-1:0]     buf_word;

    mux_dly_timer #(.CW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .len   (t_len),
        .done  (t_done)
    );

    mux_rfsh_sched #(.INTERVAL(RFSH_INT), .HW(HW)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (rf_go),
        .pend  (rf_pend),
        .row   (rf_row)
    );

    mux_row_buffer #(.HW(HW), .DW(DW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (buf_load),
        .row_in (mem_row_rdata),
        .merge  (buf_merge),
        .col    (col_q),
        .wdata  (wd_q),
        .row_q  (buf_row),
        .word   (buf_word)
    );

    assign rf_go     = (state_q == S_IDLE) && rf_pend;
    assign acc       = (state_q == S_IDLE) && !rf_pend && req_valid;
    assign col_fin   = (state_q == S_COL) && t_done;
    assign buf_load  = (state_q == S_ACT) && t_done;
    assign buf_merge = col_fin && (op_q == OP_WR);

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            S_IDLE: if (rf_pend || req_valid) nxt = S_ACT;
            S_ACT:  if (t_done) nxt = (op_q == OP_RF) ? S_WB : S_COL;
            S_COL:  if (t_done) nxt = S_WB;
            S_WB:   if (t_done) nxt = S_PRE;
            S_PRE:  if (t_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign t_start = (nxt != state_q);

    always_comb begin
        unique case (nxt)
            S_ACT:   t_len = TW'(T_RCD);
            S_COL:   t_len = TW'(T_CL);
            S_WB:    t_len = TW'(T_RAS);
            S_PRE:   t_len = TW'(T_RP);
            default: t_len = TW'(1);
        endcase
    end

    // State register and per-access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            op_q      <= OP_RD;
            row_q     <= '0;
            col_q     <= '0;
            wd_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state_q   <= nxt;
            rsp_valid <= col_fin && (op_q == OP_RD);
            if (col_fin && (op_q == OP_RD)) begin
                rsp_rdata <= buf_word;
            end
            if (rf_go) begin
                op_q  <= OP_RF;
                row_q <= rf_row;
            end else if (acc) begin
                op_q  <= req_write ? OP_WR : OP_RD;
                row_q <= req_addr[AW-1:HW];
                col_q <= req_addr[HW-1:0];
                wd_q  <= req_wdata;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready     = (state_q == S_IDLE) && !rf_pend;
        mem_row_stb   = (state_q == S_ACT);
        mem_col_stb   = (state_q == S_COL);
        mem_wb_stb    = (state_q == S_WB);
        mem_row_wdata = buf_row;
        unique case (state_q)
            S_ACT, S_WB: mem_addr = row_q;
            S_COL:       mem_addr = col_q;
            default:     mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/mux_dram_ctrl_chk.sv
module mux_dram_ctrl_chk #(
    parameter int HW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_row_stb,
    input logic          mem_col_stb,
    input logic          mem_wb_stb,
    input logic [HW-1:0] mem_addr
);
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_row_stb, mem_col_stb, mem_wb_stb}));

    a_r2_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_col_stb) |-> $past(mem_row_stb));

    a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_row_stb && $past(mem_row_stb)) || (mem_col_stb && $past(mem_col_stb))
        |-> $stable(mem_addr));

    a_r5_wb_follows_col: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_col_stb) |-> mem_wb_stb);

    a_r6_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(mem_row_stb || mem_col_stb || mem_wb_stb));

    a_r3_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind mux_dram_ctrl mux_dram_ctrl_chk #(.HW(HW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_row_stb (mem_row_stb),
    .mem_col_stb (mem_col_stb),
    .mem_wb_stb  (mem_wb_stb),
    .mem_addr    (mem_addr)
);

// File: tb/test_mux_dram_ctrl.sv
module test_mux_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HW       = 3;
    localparam int DW       = 8;
    localparam int T_RP     = 2;
    localparam int T_RCD    = 3;
    localparam int T_CL     = 2;
    localparam int T_RAS    = 3;
    localparam int RFSH_INT = 60;
    localparam int NW       = 1 << HW;
    localparam int NA       = NW * NW;
    localparam int ROWW     = NW * DW;
    localparam int CYC      = T_RCD + T_CL + T_RAS + T_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [2*HW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_row_stb, mem_col_stb, mem_wb_stb;
    logic [DW-1:0] rsp_rdata;
    logic [HW-1:0] mem_addr;
    logic [ROWW-1:0] mem_row_rdata, mem_row_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_dram_ctrl #(.HW(HW), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL),
                    .T_RAS(T_RAS), .RFSH_INT(RFSH_INT)) i_mux_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_row_stb(mem_row_stb), .mem_col_stb(mem_col_stb), .mem_wb_stb(mem_wb_stb),
        .mem_row_rdata(mem_row_rdata), .mem_row_wdata(mem_row_wdata)
    );

    // Behavioural array: a row is erased once its row strobe drops
    logic [ROWW-1:0] arr [NW];
    logic ras_d;
    logic [HW-1:0] addr_d;
    assign mem_row_rdata = arr[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) arr[i] <= '0;
            ras_d  <= 1'b0;
            addr_d <= '0;
        end else begin
            ras_d  <= mem_row_stb;
            addr_d <= mem_addr;
            if (ras_d && !mem_row_stb) arr[addr_d] <= '0;
            if (mem_wb_stb) arr[mem_addr] <= mem_row_wdata;
        end
    end

    // Port monitors
    bit mon_on = 1'b0;
    int n_rise = 0, n_acc = 0, n_col_mon = 0, n_multi = 0, rf_n = 0;
    int rf_log [32];
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_row_stb && !ras_d) begin
                n_rise <= n_rise + 1;
                if (mon_on) begin
                    rf_log[rf_n % 32] <= int'(mem_addr);
                    rf_n <= rf_n + 1;
                end
            end
            if (req_valid && req_ready) n_acc <= n_acc + 1;
            if (mon_on && mem_col_stb) n_col_mon <= n_col_mon + 1;
            if ((32'(mem_row_stb) + 32'(mem_col_stb) + 32'(mem_wb_stb)) > 1)
                n_multi <= n_multi + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 29 + 7 + salt * 53);
    endfunction

    task automatic do_access(input bit wr, input int a, input logic [DW-1:0] wd,
                             output logic [DW-1:0] rd, output int k);
        int row, col, wbn;
        row = a >> HW;
        col = a & (NW - 1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = (2*HW)'(a); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        chk(mem_row_stb && (int'(mem_addr) == row), "R2 row phase", int'(mem_addr), row);
        repeat (T_RCD) @(negedge clk);
        k += T_RCD;
        chk(mem_col_stb && (int'(mem_addr) == col), "R2 column phase", int'(mem_addr), col);
        repeat (T_CL) @(negedge clk);
        k += T_CL;
        chk(mem_wb_stb && (int'(mem_addr) == row), "R5 writeback row", int'(mem_addr), row);
        if (wr) chk(rsp_valid == 1'b0, "R10 no response on write", int'(rsp_valid), 0);
        else    chk(rsp_valid == 1'b1, "R3 response timing", int'(rsp_valid), 1);
        rd = rsp_rdata;
        wbn = 0;
        while (mem_wb_stb) begin
            wbn++;
            @(negedge clk);
            k++;
        end
        chk(wbn == T_RAS, "R5 writeback length", wbn, T_RAS);
        chk(rsp_valid == 1'b0, "R3 pulse ended", int'(rsp_valid), 0);
        while (!req_ready) begin
            @(negedge clk);
            k++;
        end
        chk(k >= CYC + 1, "R6 cycle time", k, CYC + 1);
    endtask

    logic [DW-1:0] shadow [NA];

    initial begin
        logic [DW-1:0] rd;
        int k, r0, a0, t0;
        repeat (4) @(negedge clk);
        chk(req_ready && !mem_row_stb && !mem_col_stb && !mem_wb_stb && !rsp_valid,
            "R1 reset state", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_row_stb && !mem_col_stb && !mem_wb_stb && !rsp_valid,
            "R1 after reset", int'(req_ready), 1);

        // First access: no refresh can be pending yet
        do_access(1'b1, 0, pat(0, 0), rd, k);
        shadow[0] = pat(0, 0);
        chk(k == CYC + 1, "R6 exact cycle time", k, CYC + 1);

        // Write sweep then read sweep over every address
        for (int a = 1; a < NA; a++) begin
            do_access(1'b1, a, pat(a, 0), rd, k);
            shadow[a] = pat(a, 0);
        end
        for (int a = 0; a < NA; a++) begin
            do_access(1'b0, a, '0, rd, k);
            chk(rd == shadow[a], "R3 read data", int'(rd), int'(shadow[a]));
        end
        // Re-read: destructive reads must have been written back
        for (int a = 0; a < NA; a += 5) begin
            do_access(1'b0, a, '0, rd, k);
            chk(rd == shadow[a], "R5 data survives read", int'(rd), int'(shadow[a]));
        end

        // Single-word merge leaves row neighbours intact
        for (int c = 0; c < NW; c++) begin
            a0 = 5 * NW + c;
            if (c == 3) begin
                do_access(1'b1, a0, 8'hA5, rd, k);
                shadow[a0] = 8'hA5;
            end
        end
        for (int c = 0; c < NW; c++) begin
            a0 = 5 * NW + c;
            do_access(1'b0, a0, '0, rd, k);
            chk(rd == shadow[a0], "R4 merge isolation", int'(rd), int'(shadow[a0]));
        end

        // Idle window: only refreshes run
        @(negedge clk);
        mon_on = 1'b1;
        repeat (8 * RFSH_INT) @(negedge clk);
        mon_on = 1'b0;
        repeat (CYC + 2) @(negedge clk);
        chk(rf_n >= 7 && rf_n <= 9, "R7 refresh rate", rf_n, 8);
        chk(n_col_mon == 0, "R7 no column phase in refresh", n_col_mon, 0);
        r0 = rf_log[0];
        for (int i = 1; i < rf_n && i < 32; i++) begin
            chk(rf_log[i] == ((r0 + i) % NW), "R7 row order", rf_log[i], (r0 + i) % NW);
        end
        for (int a = 0; a < NA; a++) begin
            do_access(1'b0, a, '0, rd, k);
            chk(rd == shadow[a], "R7 data retained", int'(rd), int'(shadow[a]));
        end

        // Saturating stream: refresh must keep its rate
        a0 = n_rise - n_acc;
        t0 = 0;
        for (int i = 0; i < 48; i++) begin
            do_access(1'b0, (i * 11) % NA, '0, rd, k);
            t0 += k + 1;
            chk(rd == shadow[(i * 11) % NA], "R8 read under load", int'(rd),
                int'(shadow[(i * 11) % NA]));
        end
        chk((n_rise - n_acc - a0) >= (t0 / RFSH_INT) - 1, "R8 refresh under load",
            n_rise - n_acc - a0, t0 / RFSH_INT);
        chk(n_multi == 0, "R9 strobe exclusivity", n_multi, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule